// File: doc/BRIEF.md
# Bus-Attached Serial Port with Empty/Full Flags

This block is an asynchronous serial port that sits on an 8-bit processor bus as two byte-wide registers. A transmitter with one holding register and no queue sends characters on `txd`. A receiver finds the start of each character on `rxd`, samples each bit in its middle and keeps one finished byte for the processor. Two status flags tell software when it may send and when it may read. A single interrupt line goes high when either flag changes from clear to set.

The bit period is a fixed number of system clocks, `BIT_CLKS`. An 8 MHz clock divided by 32 gives 250 kbaud. Divided by 64 it gives 125 kbaud, the slowest rate in use, where one 10-bit character lasts 640 clocks. A register address of 0 selects the data register and 1 selects the status register. A bus access is one cycle with `bus_sel` high. The read data is combinational, and the clearing side effects take place at the clock edge that ends the access.

Top module: `serial_port_bus`

## Requirements
- R1: After reset `txd` is high, `irq` is low and the status register reads 0x80: transmit-empty is set and receive-full is clear.
- R2: A status read returns the transmit-empty flag in bit 7 and the receive-full flag in bit 0. Bits 6 to 1 read as zero.
- R3: A write to register 0 while the transmitter is idle starts a character on the next cycle. The character is one low start bit, the eight data bits least significant first and one high stop bit, each `BIT_CLKS` cycles long. Transmit-empty reads 0 until the stop bit has ended.
- R4: Between characters `txd` stays high.
- R5: A write to register 0 while a character is being sent is dropped and does not alter the character on the line.
- R6: A character with a low start at mid-bit and a high stop bit at mid-bit sets receive-full and puts its byte in register 0. A byte that arrives while receive-full is still set replaces the held byte.
- R7: A read of register 0 clears receive-full.
- R8: `irq` is raised only when transmit-empty or receive-full changes from 0 to 1. A byte that arrives while receive-full is already set raises no new request.
- R9: A write to register 1 clears the pending interrupt. It leaves both flags unchanged and starts no transmission.
- R10: A low pulse on `rxd` that has ended by the start bit's mid-point is ignored and sets no flag.
- R11: A character whose stop bit samples low is discarded: receive-full and the held byte stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions take for granted that bus strobes last one cycle and that `rxd` holds each bit for close to `BIT_CLKS` cycles, so the mid-bit sample falls well inside every bit. The stimulus meets this in two ways. Every bus access is driven for exactly one clock. The serial line is driven by a task that holds each bit for a whole bit period, and the only departures from this are the deliberately short glitch and the shortened bad stop bit.

// File: rtl/serial_pkg.sv
// Shared constants and types for the bus serial port.
// Assumes a one-bit register address and an 8-bit data path.
package serial_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
    localparam int STAT_TX_EMPTY = 7;
    localparam int STAT_RX_FULL  = 0;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/serial_rx.sv
// Receiver: synchronises the line, waits for a falling edge and checks the
// start bit at mid-bit, where a high line means a glitch and a return to idle.
// It then samples eight data bits and the stop bit at their mid-points and
// pulses byte_ok for one cycle when the stop bit is high.
// Assumes BIT_CLKS >= 4.
module serial_rx
    import serial_pkg::*;
#(
    parameter int BIT_CLKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              byte_ok,
    output logic [DATA_W-1:0] byte_out
);
    localparam int CNT_W  = $clog2(BIT_CLKS);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(BIT_CLKS - 1);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(BIT_CLKS / 2 - 1);

    logic [1:0]        sync_q;
    logic              line;
    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;

    assign line = sync_q[1];

    // Two-stage synchroniser for the asynchronous line, resetting to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_in};
    end

    // Frame state machine with the mid-bit sampling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            byte_ok  <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_ok <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!line) begin
                        cnt   <= HALF_M1;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (line) begin
                        state <= RX_IDLE;
                    end else begin
                        cnt   <= FULL_M1;
                        idx   <= '0;
                        state <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        shreg <= {line, shreg[DATA_W-1:1]};
                        cnt   <= FULL_M1;
                        if (idx == IDX_W'(DATA_W - 1)) state <= RX_STOP;
                        else                           idx   <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= RX_IDLE;
                        if (line) begin
                            byte_ok  <= 1'b1;
                            byte_out <= shreg;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_tx.sv
// Transmitter: one holding shift register and no queue. A load while busy is
// ignored. last_bit is high in the final cycle of the stop bit.
// Assumes BIT_CLKS >= 2.
module serial_tx
    import serial_pkg::*;
#(
    parameter int BIT_CLKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              last_bit,
    output logic              line_out
);
    localparam int CNT_W = $clog2(BIT_CLKS);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(BIT_CLKS - 1);

    logic [FRAME_BITS-1:0] frame;
    logic [CNT_W-1:0]      cnt;
    logic [IDX_W-1:0]      idx;

    assign last_bit = busy && (cnt == '0) && (idx == IDX_W'(FRAME_BITS - 1));
    assign line_out = busy ? frame[0] : 1'b1;

    // Loads a frame when idle and shifts one bit out per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            cnt   <= '0;
            idx   <= '0;
        end else if (!busy) begin
            if (load) begin
                frame <= {1'b1, load_data, 1'b0};
                busy  <= 1'b1;
                cnt   <= FULL_M1;
                idx   <= '0;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (last_bit) begin
            busy <= 1'b0;
        end else begin
            frame <= {1'b1, frame[FRAME_BITS-1:1]};
            idx   <= idx + 1'b1;
            cnt   <= FULL_M1;
        end
    end
endmodule

// File: rtl/serial_flags.sv
// Flag and interrupt logic: keeps the received byte and the receive-full
// flag. It raises one pending bit per flag on that flag's 0-to-1 change, and
// a set wins over a clear in the same cycle.
// Assumes every access strobe lasts one cycle.
module serial_flags
    import serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ok,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_last,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              stat_wr,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_hold,
    output logic              irq
);
    logic rx_pend;
    logic tx_pend;

    assign irq = rx_pend | tx_pend;

    // Receive holding register and full flag; a new byte overwrites the old.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_hold <= '0;
        end else if (rx_ok) begin
            rx_full <= 1'b1;
            rx_hold <= rx_byte;
        end else if (data_rd) begin
            rx_full <= 1'b0;
        end
    end

    // Receive request: set on empty-to-full, cleared by a data read or status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rx_pend <= 1'b0;
        else if (rx_ok && !rx_full) rx_pend <= 1'b1;
        else if (data_rd || stat_wr) rx_pend <= 1'b0;
    end

    // Transmit request: set as the stop bit ends, cleared by any register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tx_pend <= 1'b0;
        else if (tx_last)            tx_pend <= 1'b1;
        else if (data_wr || stat_wr) tx_pend <= 1'b0;
    end
endmodule

// File: rtl/serial_port_bus.sv
// Top of the bus serial port: decodes the two registers and connects the
// receiver, the transmitter and the flag logic. Reads are combinational.
// Assumes a one-cycle bus_sel strobe for each access.
module serial_port_bus
    import serial_pkg::*;
#(
    parameter int BIT_CLKS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    logic              data_rd, data_wr, stat_wr;
    logic              rx_ok, rx_full, tx_busy, tx_last;
    logic [DATA_W-1:0] rx_byte, rx_hold;
    logic [7:0]        stat_word;

    assign data_rd = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
    assign data_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_DATA);
    assign stat_wr = bus_sel &&  bus_wr && (bus_addr == ADDR_STAT);

    // Builds the status word from the two flags.
    always_comb begin
        stat_word                = '0;
        stat_word[STAT_TX_EMPTY] = !tx_busy;
        stat_word[STAT_RX_FULL]  = rx_full;
    end

    assign bus_rdata = (bus_addr == ADDR_STAT) ? stat_word : rx_hold;

    serial_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rxd),
        .byte_ok  (rx_ok),
        .byte_out (rx_byte)
    );

    serial_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_wr),
        .load_data (bus_wdata),
        .busy      (tx_busy),
        .last_bit  (tx_last),
        .line_out  (txd)
    );

    serial_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_ok   (rx_ok),
        .rx_byte (rx_byte),
        .tx_last (tx_last),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .stat_wr (stat_wr),
        .rx_full (rx_full),
        .rx_hold (rx_hold),
        .irq     (irq)
    );
endmodule

// File: rtl/serial_port_bus_chk.sv
// Checker bound into the serial port top: relates the bus decode, the
// transmitter, the receiver and the flag logic over time.
module serial_port_bus_chk (
    input logic clk,
    input logic rst_n,
    input logic data_wr,
    input logic data_rd,
    input logic stat_wr,
    input logic tx_busy,
    input logic tx_last,
    input logic txd,
    input logic rx_ok,
    input logic rx_full,
    input logic irq
);
    // R3: an accepted write puts the start bit on the line next cycle
    assert_tx_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tx_busy) |=> (tx_busy && !txd));

    // R4: the line is high whenever no character is in flight
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !data_wr) |=> (txd || tx_busy));

    // R5: a write during a character does not restart it
    assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_busy && !tx_last) |=> tx_busy);

    // R7: a data read empties the receive buffer unless a byte lands at once
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_ok) |=> !rx_full);

    // R8: a request rises only together with a flag's rise
    assert_irq_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($fell(tx_busy) || $rose(rx_full)));

    // R9: a status write drops the request when no flag rises with it
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !rx_ok && !tx_last) |=> !irq);
endmodule

bind serial_port_bus serial_port_bus_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .stat_wr (stat_wr),
    .tx_busy (tx_busy),
    .tx_last (tx_last),
    .txd     (txd),
    .rx_ok   (rx_ok),
    .rx_full (rx_full),
    .irq     (irq)
);

// File: tb/serial_port_bus_tb.sv
// Bench for the bus serial port: random bytes from a fixed seed plus directed
// glitch, framing, overwrite and interrupt cases.
module serial_port_bus_tb;
    localparam int BITC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    serial_port_bus #(.BIT_CLKS(BITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq)
    );

    function automatic logic [7:0] exp_status(bit tx_empty, bit rx_full);
        return {tx_empty, 6'b0, rx_full};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input bit a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input bit a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Sends one frame on rxd; stop_len is how long the stop level is held.
    task automatic send_frame(input logic [7:0] d, input bit stop_val, input int stop_len);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BITC) @(negedge clk);
        end
        rxd = stop_val;
        repeat (stop_len) @(negedge clk);
        rxd = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    // Writes a byte and captures the frame on txd at each mid-bit.
    task automatic send_and_capture(input logic [7:0] d, input logic [7:0] spoil,
                                    output logic [9:0] got, output logic [7:0] mid_stat);
        bus_write(1'b0, d);
        repeat (BITC / 2 - 1) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            got[k] = txd;
            if (k == 3) begin
                bus_write(1'b0, spoil);
                repeat (BITC - 2) @(negedge clk);
            end else if (k == 5) begin
                bus_read(1'b1, mid_stat);
                repeat (BITC - 2) @(negedge clk);
            end else begin
                repeat (BITC) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, b, st;
        logic [9:0] fr;
        int seed;
        seed = $urandom(32'd2718);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(irq == 1'b0, "R1 irq", irq, 0);
        bus_read(1'b1, v);
        check(v == exp_status(1, 0), "R1/R2 status", v, exp_status(1, 0));

        // R3/R5 transmit random bytes; a mid-frame write must be dropped
        for (int n = 0; n < 6; n++) begin
            b = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : 8'($urandom);
            send_and_capture(b, ~b, fr, st);
            check(fr == {1'b1, b, 1'b0}, "R3/R5 tx frame", fr, {1'b1, b, 1'b0});
            check(st == exp_status(0, 0), "R3 busy status", st, exp_status(0, 0));
            repeat (BITC) @(negedge clk);
            check(irq == 1'b1, "R8 tx empty irq", irq, 1);
            bus_read(1'b1, v);
            check(v == exp_status(1, 0), "R2 status after tx", v, exp_status(1, 0));
        end

        // R9 status write clears irq, starts nothing; R4 line idles high
        bus_write(1'b1, 8'h55);
        check(irq == 1'b0, "R9 irq cleared", irq, 0);
        for (int k = 0; k < 4; k++) begin
            repeat (BITC / 2) @(negedge clk);
            check(txd == 1'b1, "R4/R9 line idle", txd, 1);
        end
        bus_read(1'b1, v);
        check(v == exp_status(1, 0), "R9 flags kept", v, exp_status(1, 0));

        // R6/R7/R8 receive random bytes
        for (int n = 0; n < 6; n++) begin
            b = 8'($urandom);
            send_frame(b, 1'b1, BITC);
            check(irq == 1'b1, "R8 rx irq", irq, 1);
            bus_read(1'b1, v);
            check(v == exp_status(1, 1), "R6 rx full", v, exp_status(1, 1));
            bus_read(1'b0, v);
            check(v == b, "R6 rx data", v, b);
            bus_read(1'b1, v);
            check(v == exp_status(1, 0), "R7 read clears", v, exp_status(1, 0));
            check(irq == 1'b0, "R7 irq after read", irq, 0);
        end

        // R6/R8 overwrite: second byte replaces first, no new request after clear
        send_frame(8'hA5, 1'b1, BITC);
        bus_write(1'b1, 8'h00);
        check(irq == 1'b0, "R9 rx irq cleared", irq, 0);
        send_frame(8'h3C, 1'b1, BITC);
        check(irq == 1'b0, "R8 no second edge", irq, 0);
        bus_read(1'b0, v);
        check(v == 8'h3C, "R6 overwrite", v, 8'h3C);

        // R10 short glitch ignored
        @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        bus_read(1'b1, v);
        check(v == exp_status(1, 0), "R10 glitch", v, exp_status(1, 0));
        check(irq == 1'b0, "R10 irq", irq, 0);

        // R11 low stop bit discards the frame
        send_frame(8'h81, 1'b0, (BITC * 3) / 4);
        repeat (2 * BITC) @(negedge clk);
        bus_read(1'b1, v);
        check(v == exp_status(1, 0), "R11 framing", v, exp_status(1, 0));
        bus_read(1'b0, v);
        check(v == 8'h3C, "R11 byte kept", v, 8'h3C);
        check(irq == 1'b0, "R11 irq", irq, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule